// File: doc/BRIEF.md
# Secondary Interrupt Bank

This block gathers up to a parameterized number of interrupt sources (24 by default) and presents them to two independent host interrupt lines. Each source is watched by an edge detector that can be set to react to rising edges, falling edges, both, or neither. A detected event sets the source's status bit on both lines at once. Each line then filters its status through its own mask register to drive an active-low interrupt pin and a summary bit. The summary bit feeds a primary aggregation stage, which reports this bank as one bit of its own status word.

Software reaches the bank through a byte-wide register port. One control byte selects how a status bit is acknowledged: either reading the status byte clears the bits it returned, or software writes ones to the bits it wants cleared. A second control bit governs what happens when an event arrives for a source whose status is still pending. With buffering on, the extra event is held and brings the status bit back once after it is cleared. With buffering off, the extra event is dropped.

Top module: `sih_bank`

## Requirements
- R1: After reset, every status bit and the control byte read 0, every mask bit reads 1, every edge field reads 0, `irqN` is 2'b11 and `summary` is 2'b00.
- R2: The edge field of source i is in edge byte i/4 at bits (i mod 4)*2+1 and (i mod 4)*2. The upper bit enables rising-edge detection and the lower bit enables falling-edge detection. Only an enabled edge sets a status bit.
- R3: A source whose two edge bits are both 0 never sets a status bit. With no register access and no detected event, the status registers hold their value.
- R4: A detected event sets the source's status bit on both lines, whatever the mask values. Clearing a status bit on one line leaves the other line's status unchanged.
- R5: A mask bit of 1 keeps its source from asserting that line. `irqN[l]` is low and `summary[l]` is high exactly when line l has a status bit that is set and whose mask bit is 0.
- R6: With control bit 0 (clear-on-read) set, a read of a status byte returns its value and clears the bits that were returned. Writes to status bytes then have no effect.
- R7: With control bit 0 clear, writing a 1 to a status bit clears it, writing 0 leaves it unchanged, and reads do not clear.
- R8: `irqN` and `summary` are registered. They change on the clock edge after the one on which the status or mask change takes effect, so the pin deasserts one cycle after the last unmasked status bit clears.
- R9: If a clear and a new event hit the same source on the same clock edge, the event wins and the status bit stays 1.
- R10: With control bit 1 (pending-disable) clear, an event that arrives while the status bit is set is buffered. The next clear sets the status bit back to 1 once and empties the buffer. With control bit 1 set, such an event is dropped.
- R11: Address map for the default of 24 sources: control at 0, line 0 status at 1-3, line 0 mask at 4-6, line 1 status at 7-9, line 1 mask at 10-12, edge configuration at 13-18, lowest byte first in each group. Read data appears on `regRdata` on the clock edge that samples `regRd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Raw interrupt source levels |
| regAddr | input | ADDR_W | Register byte address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Registered read data |
| irqN | output | 2 | Active-low interrupt output per host line |
| summary | output | 2 | Active-high summary bit per line for the primary stage |

## Verification
The bench targets cases where a plausible mistake changes the values read back:
- A clear that lands on the same edge as a new event: a design that lets the clear win reads 0 on the second read instead of 1.
- A second event on a pending source: a design that drops it when buffering is on, or keeps it when buffering is off, shows the wrong byte after the first clear.
- The two acknowledge modes: a design that clears on read in write-to-clear mode, or accepts writes in clear-on-read mode, returns a cleared byte where a set one is expected.
- Edge fields beyond the first byte, and the one-cycle pin latency around unmask and clear: a misplaced field or an unregistered output shows up as a wrong status byte or a pin that changes one cycle early.

// File: rtl/sih_pkg.sv
package sih_pkg;

  localparam int LINES = 2;
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT0,
    SEL_MASK0,
    SEL_STAT1,
    SEL_MASK1,
    SEL_EDGE,
    SEL_NONE
  } rdSel_e;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic [LINES-1:0] wrMask;
    logic [LINES-1:0] clrStat;
    logic             clrByRead;
    logic             wrEdge;
    logic             rdEn;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
    logic [7:0]       ctrlByte;
    logic             pendDis;
  } sihStrobe_t;

endpackage

// File: rtl/sih_edge.sv
module sih_edge #(
  parameter int NUM_SRC = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcIn,
  input  logic [2*NUM_SRC-1:0] edgeCfg,
  output logic [NUM_SRC-1:0]   evt
);

  logic [NUM_SRC-1:0] syncA;
  logic [NUM_SRC-1:0] syncB;
  logic [NUM_SRC-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  // upper bit of a field: rising, lower bit: falling
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign evt[i] = (syncB[i] & ~prevQ[i] & edgeCfg[2*i+1]) |
                    (~syncB[i] & prevQ[i] & edgeCfg[2*i]);
  end

endmodule

// File: rtl/sih_ctrl.sv
module sih_ctrl
  import sih_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        ctrlWdata,
  output sihStrobe_t        strobe
);

  localparam int SB        = (NUM_SRC + 7) / 8;
  localparam int EB        = (2 * NUM_SRC + 7) / 8;
  localparam int ST0_BASE  = 1;
  localparam int MK0_BASE  = ST0_BASE + SB;
  localparam int ST1_BASE  = MK0_BASE + SB;
  localparam int MK1_BASE  = ST1_BASE + SB;
  localparam int EDGE_BASE = MK1_BASE + SB;
  localparam int ADDR_END  = EDGE_BASE + EB;

  logic             corQ;
  logic             pendDisQ;
  rdSel_e           sel;
  logic [IDX_W-1:0] idx;
  int               addrI;

  assign addrI = int'(regAddr);

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addrI == 0) begin
      sel = SEL_CTRL;
    end else if (addrI < MK0_BASE) begin
      sel = SEL_STAT0;
      idx = IDX_W'(addrI - ST0_BASE);
    end else if (addrI < ST1_BASE) begin
      sel = SEL_MASK0;
      idx = IDX_W'(addrI - MK0_BASE);
    end else if (addrI < MK1_BASE) begin
      sel = SEL_STAT1;
      idx = IDX_W'(addrI - ST1_BASE);
    end else if (addrI < EDGE_BASE) begin
      sel = SEL_MASK1;
      idx = IDX_W'(addrI - MK1_BASE);
    end else if (addrI < ADDR_END) begin
      sel = SEL_EDGE;
      idx = IDX_W'(addrI - EDGE_BASE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corQ     <= 1'b0;
      pendDisQ <= 1'b0;
    end else if (regWr && sel == SEL_CTRL) begin
      corQ     <= ctrlWdata[0];
      pendDisQ <= ctrlWdata[1];
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.rdSel      = sel;
    strobe.idx        = idx;
    strobe.rdEn       = regRd;
    strobe.wrEdge     = regWr && (sel == SEL_EDGE);
    strobe.wrMask[0]  = regWr && (sel == SEL_MASK0);
    strobe.wrMask[1]  = regWr && (sel == SEL_MASK1);
    strobe.clrStat[0] = (sel == SEL_STAT0) && (corQ ? regRd : regWr);
    strobe.clrStat[1] = (sel == SEL_STAT1) && (corQ ? regRd : regWr);
    strobe.clrByRead  = corQ;
    strobe.pendDis    = pendDisQ;
    strobe.ctrlByte   = {6'b0, pendDisQ, corQ};
  end

endmodule

// File: rtl/sih_datapath.sv
module sih_datapath
  import sih_pkg::*;
#(
  parameter int NUM_SRC = 24
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  sihStrobe_t                                    strobe,
  input  logic [NUM_SRC-1:0]                            evt,
  input  logic [7:0]                                    regWdata,
  output logic [7:0]                                    regRdata,
  output logic [2*NUM_SRC-1:0]                          edgeCfg,
  output logic [LINES-1:0][8*((NUM_SRC+7)/8)-1:0]       statVec,
  output logic [LINES-1:0][8*((NUM_SRC+7)/8)-1:0]       maskVec,
  output logic [LINES-1:0]                              irqN,
  output logic [LINES-1:0]                              summary
);

  localparam int SB  = (NUM_SRC + 7) / 8;
  localparam int SBW = SB * 8;
  localparam int EB  = (2 * NUM_SRC + 7) / 8;
  localparam int EBW = EB * 8;

  logic [EBW-1:0] edgeQ;
  logic [SBW-1:0] evtPad;
  logic [7:0]     rdByte;
  logic [7:0]     rdataQ;

  assign evtPad = SBW'(evt);

  // shared edge configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeQ <= '0;
    end else if (strobe.wrEdge) begin
      for (int b = 0; b < EB; b++) begin
        if (int'(strobe.idx) == b) edgeQ[8*b +: 8] <= regWdata;
      end
    end
  end

  assign edgeCfg = edgeQ[2*NUM_SRC-1:0];

  // per-line status, pending buffer, mask and outputs
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [SBW-1:0] statQ;
    logic [SBW-1:0] pendQ;
    logic [SBW-1:0] maskQ;
    logic [SBW-1:0] clrV;
    logic           anyLive;
    logic           irqQ;
    logic           sumQ;

    always_comb begin
      clrV = '0;
      if (strobe.clrStat[l]) begin
        for (int b = 0; b < SB; b++) begin
          if (int'(strobe.idx) == b)
            clrV[8*b +: 8] = strobe.clrByRead ? statQ[8*b +: 8] : regWdata;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statQ <= '0;
        pendQ <= '0;
        maskQ <= '1;
      end else begin
        // new event wins; a clear reloads from the buffer
        statQ <= evtPad | (clrV & pendQ) | (~clrV & statQ);
        pendQ <= (~clrV | evtPad) &
                 (pendQ | (~clrV & evtPad & statQ & {SBW{~strobe.pendDis}}));
        if (strobe.wrMask[l]) begin
          for (int b = 0; b < SB; b++) begin
            if (int'(strobe.idx) == b) maskQ[8*b +: 8] <= regWdata;
          end
        end
      end
    end

    assign anyLive = |(statQ & ~maskQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqQ <= 1'b1;
        sumQ <= 1'b0;
      end else begin
        irqQ <= ~anyLive;
        sumQ <= anyLive;
      end
    end

    assign statVec[l] = statQ;
    assign maskVec[l] = maskQ;
    assign irqN[l]    = irqQ;
    assign summary[l] = sumQ;
  end

  // read mux
  always_comb begin
    rdByte = 8'h00;
    case (strobe.rdSel)
      SEL_CTRL: rdByte = strobe.ctrlByte;
      SEL_STAT0: for (int b = 0; b < SB; b++)
                   if (int'(strobe.idx) == b) rdByte = statVec[0][8*b +: 8];
      SEL_MASK0: for (int b = 0; b < SB; b++)
                   if (int'(strobe.idx) == b) rdByte = maskVec[0][8*b +: 8];
      SEL_STAT1: for (int b = 0; b < SB; b++)
                   if (int'(strobe.idx) == b) rdByte = statVec[1][8*b +: 8];
      SEL_MASK1: for (int b = 0; b < SB; b++)
                   if (int'(strobe.idx) == b) rdByte = maskVec[1][8*b +: 8];
      SEL_EDGE:  for (int b = 0; b < EB; b++)
                   if (int'(strobe.idx) == b) rdByte = edgeQ[8*b +: 8];
      default:   rdByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= 8'h00;
    else if (strobe.rdEn) rdataQ <= rdByte;
  end

  assign regRdata = rdataQ;

endmodule

// File: rtl/sih_bank.sv
module sih_bank
  import sih_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [7:0]         regWdata,
  output logic [7:0]         regRdata,
  output logic [1:0]         irqN,
  output logic [1:0]         summary
);

  localparam int SBW = 8 * ((NUM_SRC + 7) / 8);

  sihStrobe_t                   strobe;
  logic [NUM_SRC-1:0]           evt;
  logic [2*NUM_SRC-1:0]         edgeCfg;
  logic [LINES-1:0][SBW-1:0]    statVec;
  logic [LINES-1:0][SBW-1:0]    maskVec;

  sih_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .ctrlWdata (regWdata[1:0]),
    .strobe    (strobe)
  );

  sih_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .edgeCfg (edgeCfg),
    .evt     (evt)
  );

  sih_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .evt      (evt),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .edgeCfg  (edgeCfg),
    .statVec  (statVec),
    .maskVec  (maskVec),
    .irqN     (irqN),
    .summary  (summary)
  );

endmodule

// File: rtl/sih_bank_chk.sv
module sih_bank_chk #(
  parameter int NUM_SRC = 24
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 regRd,
  input logic                                 regWr,
  input logic [NUM_SRC-1:0]                   evt,
  input logic [1:0][8*((NUM_SRC+7)/8)-1:0]    statVec,
  input logic [1:0][8*((NUM_SRC+7)/8)-1:0]    maskVec,
  input logic [1:0]                           irqN,
  input logic [1:0]                           summary
);

  for (genvar l = 0; l < 2; l++) begin : g_chk
    // R5 / R8: pin follows unmasked status one cycle later
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
      irqN[l] == !$past(|(statVec[l] & ~maskVec[l])));

    // R5: summary is the active-high view of the same line
    a_r5_summary_matches: assert property (@(posedge clk) disable iff (!rstN)
      summary[l] == !irqN[l]);

    // R9: an event always leaves its status bit set
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rstN)
      (evt != '0) |=> ((($past(evt)) & ~statVec[l][NUM_SRC-1:0]) == '0));

    // R3: status holds with no access and no event
    a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!regRd && !regWr && evt == '0) |=> $stable(statVec[l]));
  end

endmodule

bind sih_bank sih_bank_chk #(.NUM_SRC(NUM_SRC)) u_sih_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regRd   (regRd),
  .regWr   (regWr),
  .evt     (evt),
  .statVec (statVec),
  .maskVec (maskVec),
  .irqN    (irqN),
  .summary (summary)
);

// File: tb/test_sih_bank.sv
`timescale 1ns/1ps
module test_sih_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] srcIn = '0;
  logic [4:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic [1:0]  irqN;
  logic [1:0]  summary;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;

  always #5 clk = ~clk;

  sih_bank #(.NUM_SRC(24), .ADDR_W(5)) i_sih_bank (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irqN(irqN), .summary(summary)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all driver tasks start and end just after a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rdSeen <= regRd;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        chk(32'h1, 32'h0, "R11 unexpected read result");
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({24'h0, regRdata}, {24'h0, e}, t);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all-requirements actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 / R11: reset state
    chk(irqN, 2'b11, "R1 irqN after reset");
    chk(summary, 2'b00, "R1 summary after reset");
    rdReg(5'd0, 8'h00, "R1 control reset");
    rdReg(5'd1, 8'h00, "R1 line0 status reset");
    rdReg(5'd4, 8'hFF, "R1 line0 mask reset");
    rdReg(5'd12, 8'hFF, "R1 R11 line1 mask byte2 reset");
    rdReg(5'd13, 8'h00, "R1 edge byte0 reset");

    // R3: no trigger with zero edge fields
    srcIn[0] = 1'b1; idle(4);
    srcIn[0] = 1'b0; srcIn[1] = 1'b1; idle(4);
    rdReg(5'd1, 8'h00, "R3 untriggered line0");
    rdReg(5'd7, 8'h00, "R3 untriggered line1");

    // R2: src0 rising (0x02), src1 falling (0x04), src5 both, src17 rising
    wrReg(5'd13, 8'h06);
    wrReg(5'd14, 8'h0C);
    wrReg(5'd17, 8'h08);
    idle(2);
    srcIn[0] = 1'b1; idle(4);
    rdReg(5'd1, 8'h01, "R2 rising edge src0");
    rdReg(5'd7, 8'h01, "R4 line1 sees same event");
    chk(irqN, 2'b11, "R5 masked source keeps pins high");
    srcIn[0] = 1'b0; idle(4);
    rdReg(5'd1, 8'h01, "R2 falling not enabled src0");
    srcIn[1] = 1'b0; idle(4);
    rdReg(5'd1, 8'h03, "R2 falling edge src1");
    srcIn[1] = 1'b1; idle(4);
    rdReg(5'd1, 8'h03, "R2 rising not enabled src1");
    srcIn[17] = 1'b1; idle(4);
    rdReg(5'd3, 8'h02, "R2 src17 field in edge byte4");
    rdReg(5'd9, 8'h02, "R4 line1 byte2");

    // R5 / R8: unmask src0 on line0
    wrReg(5'd4, 8'hFE);
    chk(irqN, 2'b11, "R8 pin registered after unmask");
    idle(1);
    chk(irqN, 2'b10, "R5 line0 asserted");
    chk(summary, 2'b01, "R5 summary line0");

    // R7 / R8: write-one-to-clear
    wrReg(5'd1, 8'h01);
    chk(irqN, 2'b10, "R8 pin holds one cycle after clear");
    idle(1);
    chk(irqN, 2'b11, "R8 pin deasserts");
    chk(summary, 2'b00, "R8 summary deasserts");
    rdReg(5'd1, 8'h02, "R7 write one clears only bit0");
    rdReg(5'd1, 8'h02, "R7 read does not clear");
    rdReg(5'd7, 8'h03, "R4 line1 unaffected by line0 clear");

    // R10: pending buffer on
    srcIn[5] = 1'b1; idle(4);
    srcIn[5] = 1'b0; idle(4);
    rdReg(5'd1, 8'h22, "R10 first event src5");
    wrReg(5'd1, 8'h20); idle(1);
    rdReg(5'd1, 8'h22, "R10 buffered event reasserts");
    wrReg(5'd1, 8'h20); idle(1);
    rdReg(5'd1, 8'h02, "R10 buffer used once");

    // R6: clear-on-read
    wrReg(5'd0, 8'h01);
    rdReg(5'd0, 8'h01, "R11 control readback");
    rdReg(5'd7, 8'h23, "R6 read returns line1 status");
    rdReg(5'd7, 8'h20, "R6 R10 cleared with buffer reload");
    rdReg(5'd7, 8'h00, "R6 line1 fully cleared");
    wrReg(5'd1, 8'h02);
    rdReg(5'd1, 8'h02, "R6 write ignored in clear-on-read");
    rdReg(5'd1, 8'h00, "R6 read cleared bit1");

    // R10: pending disable
    wrReg(5'd0, 8'h03);
    srcIn[5] = 1'b1; idle(4);
    srcIn[5] = 1'b0; idle(4);
    rdReg(5'd1, 8'h20, "R10 pend-disable first event");
    rdReg(5'd1, 8'h00, "R10 pend-disable second event dropped");

    // R9: clear and event on the same edge
    srcIn[0] = 1'b1; idle(4);
    srcIn[0] = 1'b0; idle(4);
    srcIn[0] = 1'b1;
    idle(2);
    rdReg(5'd1, 8'h01, "R9 read on event edge");
    rdReg(5'd1, 8'h01, "R9 event wins over clear");
    rdReg(5'd1, 8'h00, "R9 later read clears");

    // R5 / R8 on line1
    wrReg(5'd10, 8'hFE);
    idle(1);
    chk(irqN, 2'b01, "R5 line1 asserted");
    chk(summary, 2'b10, "R5 summary line1");
    rdReg(5'd7, 8'h21, "R6 line1 read");
    idle(1);
    chk(irqN, 2'b11, "R8 line1 deasserts after read clear");

    idle(3);
    chk(expQ.size(), 0, "R11 all reads answered");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule